// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block sits in a processor's exception unit. Each cycle it looks at every interrupt source that could want service and decides whether an interrupt should be taken. It then reports a registered pending flag together with a 5-bit code that names the single winning source.

The sources fall into five groups:
- Seven level-sensitive hardware lines: four general request lines plus halt, power-fail and machine-check lines.
- A serial interrupt and two performance-counter interrupts.
- Fifteen software interrupt levels.
- Four asynchronous system trap (AST) requests, one per processor mode.

Each group is qualified in its own way. The general lines, the serial request and the counter requests each pass through a bit of a mask register. Software levels need only their request bit. ASTs need both a request bit and an enable bit, and must also suit the current processor mode. While the core runs privileged firmware, nothing is eligible at all.

The hardware lines are asynchronous, so each one passes through a synchronizer before it is used. They are treated as levels and are never latched. Once a winner is registered, its code is held until that source stops being eligible. The flag then drops for one cycle, and the arbiter picks again.

Top module: `irq_prio_arb`

## Requirements
- R1: While reset is asserted and right after it is released with no requests, `irq_pend_o` is 0 and `irq_code_o` is 0.
- R2: Code map, where a higher code means higher priority. AST for mode m is code 4-m (kernel is 4, user is 1). Software level L (bit L-1 of `sw_req_i`) is code 4+L. Counter interrupt p is code 20+p. Serial is 22. General line n is code 23+n. Power-fail is 27, machine check is 28, halt is 29. Code 0 means nothing is pending.
- R3: When the flag is low, the next registered code is the highest code among all eligible sources, including sources that arrive in the same cycle.
- R4: A hardware line is seen at the output on the third rising edge after it changes: two synchronizer stages plus the output register. Deasserting the line removes the request; it is not latched.
- R5: `intr_mask_i` bits [3:0] enable general lines 3..0, bit 4 enables serial, and bits 5 and 6 enable counter interrupts 0 and 1 (1 = enabled). Halt, power-fail and machine-check cannot be masked.
- R6: A software level is eligible whenever its request bit is set.
- R7: The AST for mode m is eligible only when `ast_req_i[m]`, `ast_en_i[m]` and `cur_mode_i >= m` all hold (mode 0 is kernel, mode 3 is user).
- R8: One edge after `fw_mode_i` is seen high, the flag is low, and it stays low while firmware mode lasts.
- R9: While the flag is high, the code does not change, and a higher-priority arrival does not preempt it. When the held source becomes ineligible, the next cycle shows flag 0 and code 0, and arbitration resumes on the cycle after that.
- R10: A change in the software, AST, serial, counter, mask, mode or firmware inputs takes effect at the output after one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_gen_i | input | 4 | General hardware request lines, asynchronous, level-sensitive |
| halt_i | input | 1 | Halt request line, asynchronous |
| pwr_fail_i | input | 1 | Power-fail line, asynchronous |
| mach_chk_i | input | 1 | System machine-check line, asynchronous |
| serial_req_i | input | 1 | Serial interrupt request |
| perf_req_i | input | 2 | Performance-counter interrupt requests |
| intr_mask_i | input | 7 | Enable bits for the general lines, serial and counter sources |
| sw_req_i | input | 15 | Software request register, bit L-1 is level L |
| ast_req_i | input | 4 | AST request register, bit m for mode m |
| ast_en_i | input | 4 | AST enable register, bit m for mode m |
| cur_mode_i | input | 2 | Current processor mode, 0 kernel to 3 user |
| fw_mode_i | input | 1 | High while privileged firmware executes |
| irq_pend_o | output | 1 | Registered interrupt-pending flag |
| irq_code_o | output | 5 | Registered code of the winning source |

## Verification
Two behaviours can fall in the same cycle: a new higher-priority request arriving, and a registered winner being held. The bench raises software level 14 while level 2 is held, and later raises the halt line while level 14 is held. It checks that the held code persists on both following cycles. A second collision happens when the held source drops while a stronger source is already waiting. Here the bench expects exactly one cycle of flag 0 and code 0, and then the new winner on the next edge. Random mixes of all synchronous sources are judged against a priority model written from the code map.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int N_GEN     = 4;
    localparam int N_SW      = 15;
    localparam int N_AST     = 4;
    localparam int N_PERF    = 2;
    localparam int CODE_W    = 5;
    localparam int MODE_W    = 2;

    localparam int C_AST_LO  = 1;
    localparam int C_SW_LO   = C_AST_LO + N_AST;
    localparam int C_PERF_LO = C_SW_LO + N_SW;
    localparam int C_SERIAL  = C_PERF_LO + N_PERF;
    localparam int C_GEN_LO  = C_SERIAL + 1;
    localparam int C_PFAIL   = C_GEN_LO + N_GEN;
    localparam int C_MCHK    = C_PFAIL + 1;
    localparam int C_HALT    = C_MCHK + 1;
    localparam int N_CODES   = C_HALT + 1;

    localparam int MASK_W    = N_GEN + 1 + N_PERF;
    localparam int N_LINES   = N_GEN + 3;

    typedef struct packed {
        logic              pend;
        logic [CODE_W-1:0] code;
    } arb_state_t;

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_eligible.sv
module irq_eligible
    import irq_arb_pkg::*;
(
    input  logic [N_GEN-1:0]  gen_i,
    input  logic              halt_i,
    input  logic              pfail_i,
    input  logic              mchk_i,
    input  logic              serial_i,
    input  logic [N_PERF-1:0] perf_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic [N_SW-1:0]   sw_i,
    input  logic [N_AST-1:0]  ast_req_i,
    input  logic [N_AST-1:0]  ast_en_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              fw_i,
    output logic [N_CODES-1:0] elig_o
);

    logic open_w;
    assign open_w = ~fw_i;

    assign elig_o[0]        = 1'b0;
    assign elig_o[C_PFAIL]  = pfail_i & open_w;
    assign elig_o[C_MCHK]   = mchk_i  & open_w;
    assign elig_o[C_HALT]   = halt_i  & open_w;
    assign elig_o[C_SERIAL] = serial_i & mask_i[N_GEN] & open_w;

    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        assign elig_o[C_GEN_LO+g] = gen_i[g] & mask_i[g] & open_w;
    end

    for (genvar p = 0; p < N_PERF; p++) begin : g_perf
        assign elig_o[C_PERF_LO+p] = perf_i[p] & mask_i[N_GEN+1+p] & open_w;
    end

    for (genvar l = 0; l < N_SW; l++) begin : g_sw
        assign elig_o[C_SW_LO+l] = sw_i[l] & open_w;
    end

    // lower mode number sits at the higher code
    for (genvar m = 0; m < N_AST; m++) begin : g_ast
        assign elig_o[C_AST_LO+N_AST-1-m] = ast_req_i[m] & ast_en_i[m]
                                          & (int'(mode_i) >= m) & open_w;
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N      = 30,
    parameter int CODE_W = 5
) (
    input  logic [N-1:0]      vec_i,
    output logic              any_o,
    output logic [CODE_W-1:0] code_o
);

    always_comb begin
        code_o = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i]) code_o = CODE_W'(i);
        end
    end

    assign any_o = |vec_i;

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        hw_gen_i,
    input  logic              halt_i,
    input  logic              pwr_fail_i,
    input  logic              mach_chk_i,
    input  logic              serial_req_i,
    input  logic [1:0]        perf_req_i,
    input  logic [6:0]        intr_mask_i,
    input  logic [14:0]       sw_req_i,
    input  logic [3:0]        ast_req_i,
    input  logic [3:0]        ast_en_i,
    input  logic [1:0]        cur_mode_i,
    input  logic              fw_mode_i,
    output logic              irq_pend_o,
    output logic [4:0]        irq_code_o
);

    localparam int CODE_SPACE = 2**CODE_W;

    logic [N_LINES-1:0]    lines_raw, lines_s;
    logic [N_CODES-1:0]    elig;
    logic [CODE_SPACE-1:0] elig_ext;
    logic                  pick_any;
    logic [CODE_W-1:0]     pick_code;
    arb_state_t            state_d, state_q;

    assign lines_raw = {halt_i, mach_chk_i, pwr_fail_i, hw_gen_i};

    irq_line_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (lines_raw),
        .sync_o  (lines_s)
    );

    irq_eligible u_elig (
        .gen_i     (lines_s[N_GEN-1:0]),
        .halt_i    (lines_s[N_GEN+2]),
        .pfail_i   (lines_s[N_GEN]),
        .mchk_i    (lines_s[N_GEN+1]),
        .serial_i  (serial_req_i),
        .perf_i    (perf_req_i),
        .mask_i    (intr_mask_i),
        .sw_i      (sw_req_i),
        .ast_req_i (ast_req_i),
        .ast_en_i  (ast_en_i),
        .mode_i    (cur_mode_i),
        .fw_i      (fw_mode_i),
        .elig_o    (elig)
    );

    irq_prio_pick #(.N(N_CODES), .CODE_W(CODE_W)) u_pick (
        .vec_i  (elig),
        .any_o  (pick_any),
        .code_o (pick_code)
    );

    assign elig_ext = {{(CODE_SPACE-N_CODES){1'b0}}, elig};

    always_comb begin
        state_d = state_q;
        if (state_q.pend) begin
            if (!elig_ext[state_q.code]) state_d = '0;
        end else begin
            state_d.pend = pick_any;
            state_d.code = pick_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign irq_pend_o = state_q.pend;
    assign irq_code_o = state_q.code;

    assert_fw_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fw_mode_i |=> !irq_pend_o);

    assert_code_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend_o && elig_ext[irq_code_o]) |=> (irq_pend_o && $stable(irq_code_o)));

    assert_drop_on_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend_o && !elig_ext[irq_code_o]) |=> (!irq_pend_o && irq_code_o == '0));

    assert_idle_takes_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_pend_o && pick_any) |=> (irq_pend_o && irq_code_o == $past(pick_code)));

    assert_code_in_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pend_o |-> (irq_code_o != '0 && irq_code_o <= CODE_W'(C_HALT)));

    assert_ast_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend_o && !$past(irq_pend_o) && irq_code_o >= CODE_W'(C_AST_LO)
         && irq_code_o < CODE_W'(C_SW_LO))
        |-> (int'($past(cur_mode_i)) >= (C_AST_LO + N_AST - 1) - int'(irq_code_o)));

endmodule

// File: tb/sim_irq_prio_arb.sv
module sim_irq_prio_arb;

    typedef struct {
        int         due;
        logic       pend;
        logic [4:0] code;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  hw_gen = '0;
    logic        halt = 1'b0, pfail = 1'b0, mchk = 1'b0, serial = 1'b0;
    logic [1:0]  perf = '0;
    logic [6:0]  mask = '0;
    logic [14:0] sw = '0;
    logic [3:0]  areq = '0, aen = '0;
    logic [1:0]  mode = '0;
    logic        fw = 1'b0;
    logic        pend;
    logic [4:0]  code;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_prio_arb u0 (
        .clk(clk), .rst_n(rst_n), .hw_gen_i(hw_gen), .halt_i(halt),
        .pwr_fail_i(pfail), .mach_chk_i(mchk), .serial_req_i(serial),
        .perf_req_i(perf), .intr_mask_i(mask), .sw_req_i(sw),
        .ast_req_i(areq), .ast_en_i(aen), .cur_mode_i(mode),
        .fw_mode_i(fw), .irq_pend_o(pend), .irq_code_o(code)
    );

    task automatic check_now(logic p, logic [4:0] c, string tag);
        checks++;
        if (pend !== p || code !== c) begin
            errors++;
            $display("FAIL %s: actual pend=%0b code=%0d expected pend=%0b code=%0d",
                     tag, pend, code, p, c);
        end
    endtask

    // monitor: pops due items and compares
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t it;
            it = sb.pop_front();
            check_now(it.pend, it.code, it.tag);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(int d, logic p, logic [4:0] c, string tag);
        sb.push_back('{cyc + d, p, c, tag});
    endtask

    task automatic drain();
        while (sb.size() > 0) tick(1);
    endtask

    task automatic clear_all();
        hw_gen = '0; halt = 0; pfail = 0; mchk = 0; serial = 0; perf = '0;
        mask = '0; sw = '0; areq = '0; aen = '0; mode = '0; fw = 0;
        tick(5);
    endtask

    function automatic logic [4:0] ref_code(logic s, logic [1:0] pf, logic [6:0] mk,
                                            logic [14:0] swr, logic [3:0] rq,
                                            logic [3:0] en, logic [1:0] md);
        if (s && mk[4]) return 5'd22;
        for (int p = 1; p >= 0; p--) if (pf[p] && mk[5+p]) return 5'(20 + p);
        for (int l = 15; l >= 1; l--) if (swr[l-1]) return 5'(4 + l);
        for (int m = 0; m < 4; m++) if (rq[m] && en[m] && int'(md) >= m) return 5'(4 - m);
        return 5'd0;
    endfunction

    task automatic report();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog R1: actual=hung expected=finished");
        report();
    end

    initial begin
        logic [31:0] lf;
        logic [4:0]  rc;
        lf = 32'h1234_5678;

        // R1 reset state
        tick(3);
        check_now(0, 0, "R1 in reset");
        rst_n = 1;
        tick(2);
        check_now(0, 0, "R1 after release");

        // R6 / R2 each software level alone
        for (int l = 1; l <= 15; l++) begin
            sw = 15'(1) << (l - 1);
            expect_at(1, 1, 5'(4 + l), "R6");
            tick(1);
            sw = '0;
            expect_at(1, 0, 0, "R6 clear");
            tick(1);
        end
        drain(); clear_all();

        // R3 simultaneous software levels 3 and 9
        sw = 15'h0104;
        expect_at(1, 1, 13, "R3 same-cycle levels");
        tick(2); drain(); clear_all();

        // R3 random mixes of synchronous sources
        for (int k = 0; k < 12; k++) begin
            lf = lf * 32'd1103515245 + 32'd12345;
            serial = lf[3]; perf = lf[5:4]; mask = lf[13:7];
            sw = lf[28:14] & {15{lf[29]}} | (lf[28:14] & 15'h0003);
            areq = lf[9:6]; aen = lf[31:28]; mode = lf[1:0];
            rc = ref_code(serial, perf, mask, sw, areq, aen, mode);
            expect_at(1, rc != 0, rc, "R3 mix");
            tick(1);
            serial = 0; perf = '0; sw = '0; areq = '0;
            expect_at(1, 0, 0, "R3 mix clear");
            tick(2);
        end
        drain(); clear_all();

        // R7 AST qualification
        mode = 3; areq = 4'hF; aen = 4'hF;
        expect_at(1, 1, 4, "R7 kernel AST first");
        tick(2); drain(); clear_all();
        mode = 0; areq = 4'h8; aen = 4'h8;
        expect_at(1, 0, 0, "R7 mode too low");
        expect_at(2, 0, 0, "R7 mode too low");
        tick(2);
        mode = 3;
        expect_at(1, 1, 1, "R10 mode change");
        tick(2);
        mode = 2;
        expect_at(1, 0, 0, "R7 mode drop");
        tick(2); drain(); clear_all();
        mode = 3; areq = 4'h1; aen = 4'h0;
        expect_at(1, 0, 0, "R7 not enabled");
        tick(2); drain(); clear_all();

        // R4 hardware line latency and level behaviour
        mask = 7'h0F; hw_gen = 4'h4;
        expect_at(2, 0, 0, "R4 not yet");
        expect_at(3, 1, 25, "R4 line 2");
        tick(4);
        hw_gen = 4'h0;
        expect_at(2, 1, 25, "R4 still synced");
        expect_at(3, 0, 0, "R4 not latched");
        tick(4); drain(); clear_all();

        // R5 masking
        mask = 7'h00; hw_gen = 4'hF;
        expect_at(3, 0, 0, "R5 masked");
        expect_at(4, 0, 0, "R5 masked");
        tick(4);
        mask = 7'h0F;
        expect_at(1, 1, 26, "R10 mask open");
        tick(2); drain(); clear_all();
        halt = 1;
        expect_at(3, 1, 29, "R5 halt unmaskable");
        tick(4); drain(); clear_all();
        mchk = 1;
        expect_at(3, 1, 28, "R5 mchk unmaskable");
        tick(4); drain(); clear_all();
        pfail = 1;
        expect_at(3, 1, 27, "R5 pfail unmaskable");
        tick(4); drain(); clear_all();
        serial = 1; mask = 7'h10;
        expect_at(1, 1, 22, "R5 serial");
        tick(2); drain(); clear_all();
        serial = 1; perf = 2'b11; mask = 7'h40;
        expect_at(1, 1, 21, "R5 perf1 only");
        tick(2); drain(); clear_all();
        perf = 2'b01; mask = 7'h20;
        expect_at(1, 1, 20, "R5 perf0");
        tick(2); drain(); clear_all();

        // R8 firmware mode
        sw = 15'h0010;
        expect_at(1, 1, 9, "R8 before");
        tick(2);
        fw = 1;
        expect_at(1, 0, 0, "R8 blocked");
        tick(1);
        halt = 1;
        expect_at(3, 0, 0, "R8 halt blocked");
        expect_at(4, 0, 0, "R8 halt blocked");
        tick(5);
        fw = 0;
        expect_at(1, 1, 29, "R8 release");
        tick(2); drain(); clear_all();

        // R9 hold, no preemption, one-cycle gap
        sw = 15'h0002;
        expect_at(1, 1, 6, "R9 take");
        tick(2);
        sw = 15'h2002;
        expect_at(1, 1, 6, "R9 no preempt");
        expect_at(2, 1, 6, "R9 no preempt");
        tick(3);
        sw = 15'h2000;
        expect_at(1, 0, 0, "R9 gap");
        expect_at(2, 1, 18, "R9 rearb");
        tick(3);
        halt = 1;
        expect_at(3, 1, 18, "R9 halt waits");
        expect_at(4, 1, 18, "R9 halt waits");
        tick(5);
        sw = '0;
        expect_at(1, 0, 0, "R9 gap");
        expect_at(2, 1, 29, "R9 halt taken");
        tick(3); drain(); clear_all();

        report();
    end

endmodule